// File: doc/BRIEF.md
# Calendar Counter With Read Snapshot

This block keeps time of day and date in a chain of binary counters: hundredths of a second, seconds, minutes, hours, day of month, month, a two-digit year and a weekday. A prescaler divides an oscillator-rate strobe (`osc_tick`, one pulse per oscillator cycle) down to the hundredths tick. The command register picks the division ratio, and it also holds the run control and the choice between 12-hour and 24-hour format.

Software uses a byte-wide register port. Every counter can be loaded directly. A read of the hundredths byte returns the live value and, on the same edge, freezes a shadow copy of the other seven counters. Reads of those seven bytes then return the frozen copy, so a multi-byte read sees one consistent instant. The port is a plain strobe interface with no back-pressure. It accepts a read or a write on every cycle, and read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. One-cycle rollover pulses feed a neighbouring interrupt unit.

Top module: `tod_calendar`

## Requirements
- R1: The hundredths counter counts 0 to 99 and then returns to 0. Seconds and minutes count 0 to 59. Each counter carries into the next one when it wraps.
- R2: A hundredths tick occurs once every N cycles of `osc_tick` taken while running. N comes from command bits 1:0: 0 selects DIV_32K, 1 selects DIV_1M, 2 selects DIV_2M and 3 selects DIV_4M. The prescaler phase starts at 0 after reset.
- R3: In 24-hour format (command bit 2 set), hours count 0 to 23. The hour after 23 is 0, and that step raises a day carry.
- R4: In 12-hour format, hour bit 7 is the PM flag and bits 6:0 step 12, 1, 2, … 11. Going from 11 to 12 toggles PM, and going from 11 PM to 12 AM raises a day carry.
- R5: On a day carry, the day of month advances. After the month's last day (30 for months 4, 6, 9 and 11; 31 for the other months; 28 for month 2, or 29 when year mod 4 is 0) the day returns to 1 and the month advances. Month 12 returns to 1 and increments the year, and year 99 wraps to 0.
- R6: The weekday advances on every day carry, and 6 is followed by 0.
- R7: Register addresses are 0 hundredths, 1 hour, 2 minute, 3 second, 4 month, 5 day, 6 year and 7 weekday. A read of address 0 returns the live hundredths value and snapshots the other seven counters. Reads of addresses 1 to 7 return the snapshot until address 0 is read again.
- R8: Address 17 is the write-only command register. Bit 3 is run, bit 2 selects 24-hour format and bits 1:0 select the rate. Reads of address 17, and of any unmapped address, return 0.
- R9: While run is clear, neither the prescaler nor any counter advances.
- R10: A write to address 0 to 7 loads that counter on the same edge. A hundredths tick falling in that cycle is dropped for the whole chain.
- R11: `tenth_pulse`, `sec_pulse`, `min_pulse`, `hour_pulse` and `day_pulse` are each high for exactly the cycle after the edge on which the hundredths digit, second, minute, hour or day rolled over.
- R12: Reset sets time 0:00:00.00, day 1, month 1, year 0 and weekday 0. It sets the command register to 0x04 (stopped, 24-hour format, rate 0) and drives `reg_rdata` and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One strobe per oscillator cycle |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| tenth_pulse | output | 1 | Tenth-of-second rollover |
| sec_pulse | output | 1 | Second rollover |
| min_pulse | output | 1 | Minute rollover |
| hour_pulse | output | 1 | Hour rollover |
| day_pulse | output | 1 | Day rollover |

## Verification
A wrong prescaler phase or a wrong counter value shows up at the ports only through a register read, or through a rollover pulse that arrives early, late or not at all. A pulse error is caught one cycle after the faulty edge. A counter error is caught at the next read of the full snapshot. Carry faults at the year, month-length or 12-hour boundaries appear only at those exact instants, so those boundaries are reached by preloading the counters and then stepping a single tick. A stale or leaking snapshot is visible only as a mismatch between the bytes read at addresses 1 to 7 and the time at which address 0 was read.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] AD_HSEC = 5'd0;
  localparam logic [ADDR_W-1:0] AD_HOUR = 5'd1;
  localparam logic [ADDR_W-1:0] AD_MIN  = 5'd2;
  localparam logic [ADDR_W-1:0] AD_SEC  = 5'd3;
  localparam logic [ADDR_W-1:0] AD_MON  = 5'd4;
  localparam logic [ADDR_W-1:0] AD_DAY  = 5'd5;
  localparam logic [ADDR_W-1:0] AD_YEAR = 5'd6;
  localparam logic [ADDR_W-1:0] AD_WDAY = 5'd7;
  localparam logic [ADDR_W-1:0] AD_CMD  = 5'd17;
  localparam logic [ADDR_W-1:0] CNT_SPAN = 5'd8;

  localparam logic [DATA_W-1:0] HSEC_LAST = 8'd99;
  localparam logic [DATA_W-1:0] SEC_LAST  = 8'd59;
  localparam logic [DATA_W-1:0] MIN_LAST  = 8'd59;
  localparam logic [DATA_W-1:0] HR24_LAST = 8'd23;
  localparam logic [6:0]        HR12_TOP  = 7'd12;
  localparam logic [6:0]        HR12_FLIP = 7'd11;
  localparam logic [DATA_W-1:0] MON_LAST  = 8'd12;
  localparam logic [DATA_W-1:0] YEAR_LAST = 8'd99;
  localparam logic [DATA_W-1:0] WDAY_LAST = 8'd6;
  localparam logic [DATA_W-1:0] TENTH_DIV = 8'd10;
  localparam logic [3:0]        CMD_RESET = 4'b0100;

  typedef struct packed {
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] minute;
    logic [DATA_W-1:0] second;
    logic [DATA_W-1:0] month;
    logic [DATA_W-1:0] day;
    logic [DATA_W-1:0] year;
    logic [DATA_W-1:0] wday;
  } snap_t;

  function automatic logic [DATA_W-1:0] month_len(input logic [DATA_W-1:0] mon,
                                                  input logic [DATA_W-1:0] yr);
    logic [DATA_W-1:0] len;
    case (mon)
      8'd2:                   len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: len = 8'd30;
      default:                len = 8'd31;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned DIV_32K = 328,
  parameter int unsigned DIV_1M  = 10486,
  parameter int unsigned DIV_2M  = 20972,
  parameter int unsigned DIV_4M  = 41943
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       osc_tick,
  output logic       hs_tick
);
  localparam int unsigned MAX_A  = (DIV_32K > DIV_1M) ? DIV_32K : DIV_1M;
  localparam int unsigned MAX_B  = (DIV_2M > DIV_4M) ? DIV_2M : DIV_4M;
  localparam int unsigned MAXDIV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          at_end;

  always_comb begin
    case (rate)
      2'd0:    lim = CW'(DIV_32K - 1);
      2'd1:    lim = CW'(DIV_1M - 1);
      2'd2:    lim = CW'(DIV_2M - 1);
      default: lim = CW'(DIV_4M - 1);
    endcase
  end

  assign at_end  = (cnt >= lim);
  assign hs_tick = run & osc_tick & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run && osc_tick) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R9
  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hs_tick |=> (cnt == '0)); // R2
endmodule

// File: rtl/tod_wrapcnt.sv
module tod_wrapcnt #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] FIRST = '0,
  parameter logic [W-1:0] LAST  = 8'd99
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         at_last
);
  assign at_last = (q >= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= FIRST;
    end else if (ld) begin
      q <= ld_val;
    end else if (inc) begin
      q <= at_last ? FIRST : q + 1'b1;
    end
  end

  AST_WRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && at_last) |=> (q == FIRST)); // R1
endmodule

// File: rtl/tod_timechain.sv
module tod_timechain
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fmt24,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] hsec,
  output logic [DATA_W-1:0] sec,
  output logic [DATA_W-1:0] minute,
  output logic [DATA_W-1:0] hour,
  output logic              tenth_c,
  output logic              sec_c,
  output logic              min_c,
  output logic              hour_c,
  output logic              day_c
);
  logic hs_last, se_last, mi_last;
  logic hr_last;
  logic [DATA_W-1:0] hour_nxt;

  tod_wrapcnt #(.W(DATA_W), .FIRST(8'd0), .LAST(HSEC_LAST)) u_hs (
    .clk(clk), .rst_n(rst_n), .inc(tick), .ld(ld_en && ld_addr == AD_HSEC),
    .ld_val(ld_data), .q(hsec), .at_last(hs_last));

  tod_wrapcnt #(.W(DATA_W), .FIRST(8'd0), .LAST(SEC_LAST)) u_se (
    .clk(clk), .rst_n(rst_n), .inc(sec_c), .ld(ld_en && ld_addr == AD_SEC),
    .ld_val(ld_data), .q(sec), .at_last(se_last));

  tod_wrapcnt #(.W(DATA_W), .FIRST(8'd0), .LAST(MIN_LAST)) u_mi (
    .clk(clk), .rst_n(rst_n), .inc(min_c), .ld(ld_en && ld_addr == AD_MIN),
    .ld_val(ld_data), .q(minute), .at_last(mi_last));

  assign tenth_c = tick && ((hsec % TENTH_DIV) == (TENTH_DIV - 8'd1));
  assign sec_c   = tick && hs_last;
  assign min_c   = sec_c && se_last;
  assign hour_c  = min_c && mi_last;
  assign hr_last = fmt24 ? (hour >= HR24_LAST) : (hour[7] && hour[6:0] == HR12_FLIP);
  assign day_c   = hour_c && hr_last;

  always_comb begin
    if (fmt24) begin
      hour_nxt = hr_last ? 8'd0 : hour + 8'd1;
    end else if (hour[6:0] == HR12_TOP) begin
      hour_nxt = {hour[7], 7'd1};
    end else if (hour[6:0] == HR12_FLIP) begin
      hour_nxt = {~hour[7], HR12_TOP};
    end else begin
      hour_nxt = {hour[7], 7'(hour[6:0] + 7'd1)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour <= '0;
    end else if (ld_en && ld_addr == AD_HOUR) begin
      hour <= ld_data;
    end else if (hour_c) begin
      hour <= hour_nxt;
    end
  end

  AST_HOUR24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_c && fmt24 && hour == HR24_LAST) |=> (hour == 8'd0)); // R3
  AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_c && !fmt24 && hour[6:0] == HR12_FLIP) |=> (hour[7] != $past(hour[7]) && hour[6:0] == HR12_TOP)); // R4
  AST_TWELVE_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_c && !fmt24 && hour[6:0] == HR12_TOP) |=> (hour[6:0] == 7'd1)); // R4
endmodule

// File: rtl/tod_datechain.sv
module tod_datechain
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_inc,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] day,
  output logic [DATA_W-1:0] month,
  output logic [DATA_W-1:0] year,
  output logic [DATA_W-1:0] wday
);
  logic [DATA_W-1:0] mlen;
  logic month_end, year_end;
  logic yr_last, wd_last;

  assign mlen      = month_len(month, year);
  assign month_end = day_inc && (day >= mlen);
  assign year_end  = month_end && (month >= MON_LAST);

  tod_wrapcnt #(.W(DATA_W), .FIRST(8'd0), .LAST(YEAR_LAST)) u_yr (
    .clk(clk), .rst_n(rst_n), .inc(year_end), .ld(ld_en && ld_addr == AD_YEAR),
    .ld_val(ld_data), .q(year), .at_last(yr_last));

  tod_wrapcnt #(.W(DATA_W), .FIRST(8'd0), .LAST(WDAY_LAST)) u_wd (
    .clk(clk), .rst_n(rst_n), .inc(day_inc), .ld(ld_en && ld_addr == AD_WDAY),
    .ld_val(ld_data), .q(wday), .at_last(wd_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day <= 8'd1;
    end else if (ld_en && ld_addr == AD_DAY) begin
      day <= ld_data;
    end else if (day_inc) begin
      day <= month_end ? 8'd1 : day + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      month <= 8'd1;
    end else if (ld_en && ld_addr == AD_MON) begin
      month <= ld_data;
    end else if (month_end) begin
      month <= year_end ? 8'd1 : month + 8'd1;
    end
  end

  AST_LEAP_FEB: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !ld_en && month == 8'd2 && day == 8'd28 && year[1:0] == 2'b00) |=> (day == 8'd29)); // R5
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !ld_en && month == 8'd12 && day == 8'd31 && yr_last) |=> (year == 8'd0 && month == 8'd1)); // R5
  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !ld_en && wd_last) |=> (wday == 8'd0)); // R6
endmodule

// File: rtl/tod_regport.sv
module tod_regport
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] live_hsec,
  input  snap_t             live,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              fmt24,
  output logic [1:0]        rate
);
  snap_t             shadow;
  logic [3:0]        cmd;
  logic [DATA_W-1:0] rd_mux;
  logic              snap_now;

  assign run      = cmd[3];
  assign fmt24    = cmd[2];
  assign rate     = cmd[1:0];
  assign snap_now = rd_en && addr == AD_HSEC;

  always_comb begin
    case (addr)
      AD_HSEC: rd_mux = live_hsec;
      AD_HOUR: rd_mux = shadow.hour;
      AD_MIN:  rd_mux = shadow.minute;
      AD_SEC:  rd_mux = shadow.second;
      AD_MON:  rd_mux = shadow.month;
      AD_DAY:  rd_mux = shadow.day;
      AD_YEAR: rd_mux = shadow.year;
      AD_WDAY: rd_mux = shadow.wday;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '{hour: 8'd0, minute: 8'd0, second: 8'd0, month: 8'd1,
                  day: 8'd1, year: 8'd0, wday: 8'd0};
      cmd    <= CMD_RESET;
      rdata  <= '0;
    end else begin
      if (snap_now) shadow <= live;
      if (wr_en && addr == AD_CMD) cmd <= wdata[3:0];
      if (rd_en) rdata <= rd_mux;
    end
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_now |=> $stable(shadow)); // R7
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AD_CMD) |=> (rdata == '0)); // R8
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int unsigned DIV_32K = 328,
  parameter int unsigned DIV_1M  = 10486,
  parameter int unsigned DIV_2M  = 20972,
  parameter int unsigned DIV_4M  = 41943
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tenth_pulse,
  output logic              sec_pulse,
  output logic              min_pulse,
  output logic              hour_pulse,
  output logic              day_pulse
);
  logic run, fmt24;
  logic [1:0] rate;
  logic hs_tick, cnt_wr, eff_tick;
  logic tenth_c, sec_c, min_c, hour_c, day_c;
  logic [DATA_W-1:0] hsec, sec, minute, hour, day, month, year, wday;
  snap_t live;

  assign cnt_wr   = reg_wr && (reg_addr < CNT_SPAN);
  assign eff_tick = hs_tick && !cnt_wr;

  tod_prescaler #(.DIV_32K(DIV_32K), .DIV_1M(DIV_1M), .DIV_2M(DIV_2M), .DIV_4M(DIV_4M)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(rate), .osc_tick(osc_tick), .hs_tick(hs_tick));

  tod_timechain u_time (
    .clk(clk), .rst_n(rst_n), .tick(eff_tick), .fmt24(fmt24),
    .ld_en(cnt_wr), .ld_addr(reg_addr), .ld_data(reg_wdata),
    .hsec(hsec), .sec(sec), .minute(minute), .hour(hour),
    .tenth_c(tenth_c), .sec_c(sec_c), .min_c(min_c), .hour_c(hour_c), .day_c(day_c));

  tod_datechain u_date (
    .clk(clk), .rst_n(rst_n), .day_inc(day_c),
    .ld_en(cnt_wr), .ld_addr(reg_addr), .ld_data(reg_wdata),
    .day(day), .month(month), .year(year), .wday(wday));

  assign live = '{hour: hour, minute: minute, second: sec, month: month,
                  day: day, year: year, wday: wday};

  tod_regport u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .live_hsec(hsec), .live(live), .rdata(reg_rdata),
    .run(run), .fmt24(fmt24), .rate(rate));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {tenth_pulse, sec_pulse, min_pulse, hour_pulse, day_pulse} <= '0;
    end else begin
      {tenth_pulse, sec_pulse, min_pulse, hour_pulse, day_pulse} <=
        {tenth_c, sec_c, min_c, hour_c, day_c};
    end
  end

  AST_PULSE_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse |-> tenth_pulse) and (day_pulse |-> hour_pulse)); // R11
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> ($stable(hsec) && $stable(day))); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AD_HSEC) |=> (hsec == $past(reg_wdata))); // R10
  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && hsec < HSEC_LAST) |=> (hsec == $past(hsec) + 8'd1)); // R1
endmodule

// File: tb/tod_calendar_test.sv
`timescale 1ns/1ps
module tod_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       tenth_pulse, sec_pulse, min_pulse, hour_pulse, day_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_pre, m_cmd;
  int m_hs, m_hr, m_mi, m_se, m_mo, m_dy, m_yr, m_wd;
  int sh[8];

  always #2 clk = ~clk;

  tod_calendar #(.DIV_32K(4), .DIV_1M(3), .DIV_2M(2), .DIV_4M(1)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tenth_pulse(tenth_pulse), .sec_pulse(sec_pulse), .min_pulse(min_pulse),
    .hour_pulse(hour_pulse), .day_pulse(day_pulse));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int rate);
    case (rate)
      0: return 4;
      1: return 3;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick(output logic [4:0] p);
    bit t, s, mi, h, d;
    t = (m_hs % 10) == 9;
    s = m_hs == 99;
    mi = 0; h = 0; d = 0;
    m_hs = s ? 0 : m_hs + 1;
    if (s) begin
      mi = m_se == 59;
      m_se = mi ? 0 : m_se + 1;
      if (mi) begin
        h = m_mi == 59;
        m_mi = h ? 0 : m_mi + 1;
        if (h) begin
          if (m_cmd[2]) begin
            d = m_hr == 23;
            m_hr = d ? 0 : m_hr + 1;
          end else begin
            int lo;
            int pm;
            lo = m_hr % 128;
            pm = m_hr / 128;
            if (lo == 12) m_hr = pm * 128 + 1;
            else if (lo == 11) begin
              d = (pm == 1);
              m_hr = (1 - pm) * 128 + 12;
            end else m_hr = m_hr + 1;
          end
          if (d) begin
            m_wd = (m_wd == 6) ? 0 : m_wd + 1;
            if (m_dy >= mlen(m_mo, m_yr)) begin
              m_dy = 1;
              if (m_mo == 12) begin
                m_mo = 1;
                m_yr = (m_yr == 99) ? 0 : m_yr + 1;
              end else m_mo = m_mo + 1;
            end else m_dy = m_dy + 1;
          end
        end
      end
    end
    p = {t, s, mi, h, d};
  endtask

  // prescaler step of the model; returns 1 when a hundredths tick falls
  function automatic bit model_pre(input bit osc);
    if (!(m_cmd[3] && osc)) return 0;
    if (m_pre >= div_of(m_cmd % 4) - 1) begin
      m_pre = 0;
      return 1;
    end
    m_pre = m_pre + 1;
    return 0;
  endfunction

  task automatic model_write(input int a, input int d);
    case (a)
      0: m_hs = d;
      1: m_hr = d;
      2: m_mi = d;
      3: m_se = d;
      4: m_mo = d;
      5: m_dy = d;
      6: m_yr = d;
      7: m_wd = d;
      17: m_cmd = d % 16;
      default: ;
    endcase
  endtask

  function automatic int exp_reg(input int a);
    if (a == 0) return m_hs;
    if (a >= 1 && a <= 7) return sh[a];
    return 0;
  endfunction

  task automatic step(input bit osc);
    logic [4:0] ep;
    ep = '0;
    osc_tick = osc;
    @(posedge clk);
    if (model_pre(osc)) model_tick(ep);
    @(negedge clk);
    osc_tick = 1'b0;
    chk("R11 pulses", int'({tenth_pulse, sec_pulse, min_pulse, hour_pulse, day_pulse}), int'(ep));
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 5'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // write and oscillator strobe in the same cycle: the write wins (R10)
  task automatic wr_tick(input int a, input int d);
    bit dropped;
    reg_addr = 5'(a); reg_wdata = 8'(d); reg_wr = 1'b1; osc_tick = 1'b1;
    @(posedge clk);
    dropped = model_pre(1'b1);
    model_write(a, d);
    @(negedge clk);
    reg_wr = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 5'(a); reg_rd = 1'b1;
    @(posedge clk);
    if (a == 0) begin
      sh[1] = m_hr; sh[2] = m_mi; sh[3] = m_se; sh[4] = m_mo;
      sh[5] = m_dy; sh[6] = m_yr; sh[7] = m_wd;
    end
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic read_all(input string req);
    int v, e;
    e = m_hs;
    rd(0, v);
    chk({req, " hundredths"}, v, e);
    for (int a = 1; a < 8; a++) begin
      e = exp_reg(a);
      rd(a, v);
      chk({req, " counter read"}, v, e);
    end
  endtask

  task automatic preload(input int hs, input int se, input int mi, input int hr,
                         input int dy, input int mo, input int yr, input int wd);
    wr(0, hs); wr(3, se); wr(2, mi); wr(1, hr);
    wr(5, dy); wr(4, mo); wr(6, yr); wr(7, wd);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    summary();
  end

  initial begin
    int v, old_sec;
    void'($urandom(32'd20240611));
    m_pre = 0; m_cmd = 4;
    m_hs = 0; m_hr = 0; m_mi = 0; m_se = 0; m_mo = 1; m_dy = 1; m_yr = 0; m_wd = 0;
    sh[0] = 0; sh[1] = 0; sh[2] = 0; sh[3] = 0; sh[4] = 1; sh[5] = 1; sh[6] = 0; sh[7] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 rdata after reset", int'(reg_rdata), 0);
    chk("R12 pulses after reset", int'({tenth_pulse, sec_pulse, min_pulse, hour_pulse, day_pulse}), 0);
    read_all("R12");
    rd(17, v);
    chk("R8 command reads zero", v, 0);
    rd(9, v);
    chk("R8 unmapped reads zero", v, 0);

    // R9 stopped after reset: nothing advances
    repeat (20) step(1'b1);
    rd(0, v);
    chk("R9 stopped hundredths", v, 0);

    // R3 R5 R6 year end in 24-hour mode, ratio 1
    wr(17, 8'h0F);
    preload(99, 59, 59, 23, 31, 12, 99, 6);
    step(1'b1);
    chk("R11 all pulses at year end", int'({tenth_pulse, sec_pulse, min_pulse, hour_pulse, day_pulse}), 31);
    read_all("R5 year wrap");
    rd(0, v);
    rd(1, v); chk("R3 hour 23 to 0", v, 0);
    rd(6, v); chk("R5 year 99 to 0", v, 0);
    rd(7, v); chk("R6 weekday 6 to 0", v, 0);

    // R5 leap February
    preload(99, 59, 59, 23, 28, 2, 4, 2);
    step(1'b1);
    rd(0, v); rd(5, v);
    chk("R5 leap Feb 28 to 29", v, 29);
    preload(99, 59, 59, 23, 28, 2, 5, 2);
    step(1'b1);
    rd(0, v); rd(5, v);
    chk("R5 common Feb 28 to 1", v, 1);
    rd(4, v);
    chk("R5 month to March", v, 3);
    preload(99, 59, 59, 23, 30, 4, 7, 3);
    step(1'b1);
    read_all("R5 thirty-day month");

    // R4 12-hour format
    wr(17, 8'h0B);
    preload(99, 59, 59, 8'h8B, 10, 5, 20, 4);
    step(1'b1);
    rd(0, v); rd(1, v);
    chk("R4 11 PM to 12 AM", v, 12);
    rd(5, v);
    chk("R4 day carry from PM", v, 11);
    preload(99, 59, 59, 8'h0B, 10, 5, 20, 4);
    step(1'b1);
    rd(0, v); rd(1, v);
    chk("R4 11 AM to 12 PM", v, 8'h8C);
    rd(5, v);
    chk("R4 no day carry at noon", v, 10);
    preload(99, 59, 59, 8'h8C, 10, 5, 20, 4);
    step(1'b1);
    rd(0, v); rd(1, v);
    chk("R4 12 PM to 1 PM", v, 8'h81);

    // R7 snapshot stays frozen between hundredths reads
    wr(17, 8'h0F);
    wr(0, 0); wr(3, 10);
    rd(0, v);
    old_sec = 10;
    repeat (250) step(1'b1);
    rd(3, v);
    chk("R7 snapshot frozen", v, old_sec);
    rd(0, v);
    rd(3, v);
    chk("R7 snapshot refreshed", v, 12);

    // R10 write beats a same-cycle tick
    wr(0, 40);
    wr_tick(0, 7);
    rd(0, v);
    chk("R10 write wins over tick", v, 7);
    step(1'b1);
    rd(0, v);
    chk("R10 counting resumes", v, 8);

    // R2 rate selection
    wr(17, 8'h0C);
    wr(0, 0);
    repeat (8) step(1'b1);
    rd(0, v);
    chk("R2 ratio for rate 0", v, 2);
    wr(17, 8'h0D);
    wr(0, 0);
    repeat (9) step(1'b1);
    rd(0, v);
    chk("R2 ratio for rate 1", v, 3);
    repeat (5) begin
      step(1'b1);
      step(1'b0);
    end
    read_all("R2 gaps in oscillator");

    // R9 stop with run clear after running
    wr(17, 8'h07);
    repeat (30) step(1'b1);
    read_all("R9 stopped");

    // R1 R5 R6 R3 R4 constrained random runs
    for (int it = 0; it < 12; it++) begin
      int rate, f24, hr;
      rate = $urandom % 4;
      f24 = $urandom % 2;
      wr(17, 8 + f24 * 4 + rate);
      hr = f24 ? ($urandom % 24) : (($urandom % 2) * 128 + 1 + $urandom % 12);
      preload($urandom % 100, 50 + $urandom % 10, 55 + $urandom % 5, hr,
              25 + $urandom % 4, 1 + $urandom % 12, $urandom % 100, $urandom % 7);
      for (int n = 0; n < 3000; n++) step(($urandom % 3) != 0);
      read_all("R1 random run");
    end

    summary();
  end
endmodule